// File: doc/BRIEF.md
# Programmable Colour Correction Matrix

This block sits in a camera pixel pipeline and corrects the colour of an RGB stream. It fixes white balance, colour cast, brightness and contrast. Each output channel is computed as a weighted sum of the three input channels, using a row of signed fixed-point weights. The sum is rounded, a per-channel signed offset is added, and the result is bounded. An optional upper bound and an optional lower bound are applied, each with its own enable, and the result is then always saturated to the pixel range. An optional mode treats the input as cyan/magenta/yellow and complements each sample before the multiply.

Software writes the settings through a simple write-only register port into a shadow copy. The shadow copy becomes active on the first pixel of a frame, and that start-of-frame pixel already uses the new values. The stream takes one pixel per clock with no stalls and returns it three cycles later.

Top module: `color_matrix_top`

## Requirements
- R1: After reset `outValid` is low and the active settings pass every pixel through unchanged. The reset settings are: identity weights, zero offsets, upper bound 255, lower bound 0, both bounds enabled, and RGB input.
- R2: Each output channel before bounding is round(sum over c of k[r][c]·x[c] / 4096) plus offset[r]. The weights are signed 16-bit values with 12 fraction bits (range −8.0 to just under +8.0). Rounding is to nearest, and exact halves round toward +infinity.
- R3: Each channel has its own signed 9-bit offset (data bits 8:0). The offsets are at address 9 for red, 10 for green and 11 for blue.
- R4: When mode bit 1 is set, a channel value above the upper bound (address 12, bits 7:0) is replaced by that bound.
- R5: When mode bit 2 is set, a channel value below the lower bound (address 13, bits 7:0) is replaced by that bound. The lower bound is applied after the upper bound.
- R6: The final output is always saturated to 0..255, even with both bounds disabled.
- R7: When mode bit 0 is set (mode at address 14, bits 2:0), each input sample x is replaced by 255 − x before the multiply.
- R8: A pixel sampled with `inValid` high appears with `outValid` high exactly three rising edges later, counting the sampling edge as the first. Back-to-back pixels stream at one per clock, and idle cycles produce `outValid` low.
- R9: Register writes do not change the result for any pixel until a pixel is sampled with both `inValid` and `inSof` high. That pixel and every later pixel use the new values.
- R10: The weights are at addresses 0 to 8 in row-major order. The row is the output channel (R, G, B) and the column is the input channel (R, G, B). Pixels pack red in bits 23:16, green in bits 15:8 and blue in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register address |
| cfgData | input | 16 | Register write data |
| inValid | input | 1 | Input pixel valid |
| inSof | input | 1 | Input pixel is first of frame |
| inPix | input | 24 | Input pixel {R,G,B} |
| outValid | output | 1 | Output pixel valid |
| outPix | output | 24 | Corrected pixel {R,G,B} |

## Verification
The hardest situation to reach is a change of settings while older pixels are still in the pipeline. A pixel of the old frame must leave with the old offsets and bounds while the start-of-frame pixel right behind it uses the new ones. The stimulus creates this by writing new settings between frames and then sending the start-of-frame pixel immediately after a run of non-start pixels. It also sends some pixels after a write but before any start of frame. Exact rounding halves and both saturation directions are hit with directed weights of ±0.5 and large offsets. A seeded random phase mixes random weights, bounds, modes and idle gaps.

// File: rtl/color_matrix_pkg.sv
package color_matrix_pkg;
  // Mode strobes handed from control to datapath, valid for the pixel at the input.
  typedef struct packed {
    logic cmy;
    logic clipEn;
    logic clampEn;
  } ccm_strobe_t;

  localparam int NUM_CH   = 3;
  localparam int NUM_COEF = NUM_CH * NUM_CH;
  localparam int ADDR_OFS   = NUM_COEF;
  localparam int ADDR_CLIP  = NUM_COEF + NUM_CH;
  localparam int ADDR_CLAMP = ADDR_CLIP + 1;
  localparam int ADDR_MODE  = ADDR_CLAMP + 1;
endpackage

// File: rtl/color_matrix_ctrl.sv
module color_matrix_ctrl
  import color_matrix_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 12,
  parameter int OFS_W  = 9,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [DATA_W-1:0]          cfgData,
  input  logic                       inValid,
  input  logic                       inSof,
  output ccm_strobe_t                strb,
  output logic [NUM_COEF*COEF_W-1:0] coefFlat,
  output logic [NUM_CH*OFS_W-1:0]    ofsFlat,
  output logic [PIX_W-1:0]           clipMax,
  output logic [PIX_W-1:0]           clampMin
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;
  localparam logic [PIX_W-1:0]  PMAX  = {PIX_W{1'b1}};
  localparam logic [2:0]        MODE_RST = 3'b110;

  logic [COEF_W-1:0] shCoef [NUM_COEF];
  logic [COEF_W-1:0] acCoef [NUM_COEF];
  logic [OFS_W-1:0]  shOfs  [NUM_CH];
  logic [OFS_W-1:0]  acOfs  [NUM_CH];
  logic [PIX_W-1:0]  shClip, acClip, shClamp, acClamp;
  logic [2:0]        shMode, acMode;
  logic              take;

  assign take = inValid & inSof;

  // Shadow copy: written by the register port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COEF; i++) shCoef[i] <= (i % 4 == 0) ? UNITY : '0;
      for (int i = 0; i < NUM_CH; i++)   shOfs[i]  <= '0;
      shClip  <= PMAX;
      shClamp <= '0;
      shMode  <= MODE_RST;
    end else if (cfgWe) begin
      for (int i = 0; i < NUM_COEF; i++)
        if (cfgAddr == ADDR_W'(i)) shCoef[i] <= cfgData[COEF_W-1:0];
      for (int i = 0; i < NUM_CH; i++)
        if (cfgAddr == ADDR_W'(ADDR_OFS + i)) shOfs[i] <= cfgData[OFS_W-1:0];
      if (cfgAddr == ADDR_W'(ADDR_CLIP))  shClip  <= cfgData[PIX_W-1:0];
      if (cfgAddr == ADDR_W'(ADDR_CLAMP)) shClamp <= cfgData[PIX_W-1:0];
      if (cfgAddr == ADDR_W'(ADDR_MODE))  shMode  <= cfgData[2:0];
    end
  end

  // Active copy: loaded from shadow at start of frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COEF; i++) acCoef[i] <= (i % 4 == 0) ? UNITY : '0;
      for (int i = 0; i < NUM_CH; i++)   acOfs[i]  <= '0;
      acClip  <= PMAX;
      acClamp <= '0;
      acMode  <= MODE_RST;
    end else if (take) begin
      acCoef  <= shCoef;
      acOfs   <= shOfs;
      acClip  <= shClip;
      acClamp <= shClamp;
      acMode  <= shMode;
    end
  end

  // The start-of-frame pixel itself already sees the shadow values.
  logic [2:0] effMode;
  assign effMode = take ? shMode : acMode;
  assign strb.cmy     = effMode[0];
  assign strb.clipEn  = effMode[1];
  assign strb.clampEn = effMode[2];
  assign clipMax  = take ? shClip  : acClip;
  assign clampMin = take ? shClamp : acClamp;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    assign coefFlat[i*COEF_W +: COEF_W] = take ? shCoef[i] : acCoef[i];
  end
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ofs
    assign ofsFlat[i*OFS_W +: OFS_W] = take ? shOfs[i] : acOfs[i];
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(acMode) && $stable(acClip) && $stable(acClamp)
               && $stable(acOfs[0]) && $stable(acCoef[0])));
endmodule

// File: rtl/color_matrix_dp.sv
module color_matrix_dp
  import color_matrix_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 12,
  parameter int OFS_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ccm_strobe_t                strb,
  input  logic [NUM_COEF*COEF_W-1:0] coefFlat,
  input  logic [NUM_CH*OFS_W-1:0]    ofsFlat,
  input  logic [PIX_W-1:0]           clipMax,
  input  logic [PIX_W-1:0]           clampMin,
  input  logic                       inValid,
  input  logic [NUM_CH*PIX_W-1:0]    inPix,
  output logic                       outValid,
  output logic [NUM_CH*PIX_W-1:0]    outPix
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int RND_W  = SUM_W - FRAC_W;
  localparam int ACC_W  = RND_W + 1;
  localparam int HALF   = 1 << (FRAC_W - 1);
  localparam int MAXV   = (1 << PIX_W) - 1;

  // Stage 1: optional complement, nine products.
  logic [PIX_W-1:0]         xIn [NUM_CH];
  logic signed [PROD_W-1:0] prod [NUM_CH][NUM_CH];
  logic                     s1Valid;
  logic [NUM_CH*OFS_W-1:0]  s1Ofs;
  logic [PIX_W-1:0]         s1Clip, s1Clamp;
  logic                     s1ClipEn, s1ClampEn;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmy
    assign xIn[c] = strb.cmy ? (PIX_W'(MAXV) - inPix[(NUM_CH-1-c)*PIX_W +: PIX_W])
                             : inPix[(NUM_CH-1-c)*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_CH; r++)
      for (int c = 0; c < NUM_CH; c++)
        prod[r][c] <= $signed(coefFlat[(r*NUM_CH+c)*COEF_W +: COEF_W])
                      * $signed({1'b0, xIn[c]});
    s1Ofs     <= ofsFlat;
    s1Clip    <= clipMax;
    s1Clamp   <= clampMin;
    s1ClipEn  <= strb.clipEn;
    s1ClampEn <= strb.clampEn;
  end

  // Stage 2: sum, round to nearest, add offset.
  logic signed [SUM_W-1:0] sum  [NUM_CH];
  logic signed [RND_W-1:0] rnd  [NUM_CH];
  logic signed [ACC_W-1:0] acc  [NUM_CH];
  logic signed [ACC_W-1:0] s2Acc [NUM_CH];
  logic                    s2Valid;
  logic [PIX_W-1:0]        s2Clip, s2Clamp;
  logic                    s2ClipEn, s2ClampEn;

  always_comb begin
    for (int r = 0; r < NUM_CH; r++) begin
      sum[r] = SUM_W'(prod[r][0]) + SUM_W'(prod[r][1]) + SUM_W'(prod[r][2]);
      rnd[r] = RND_W'((sum[r] + SUM_W'(HALF)) >>> FRAC_W);
      acc[r] = ACC_W'(rnd[r]) + ACC_W'($signed(s1Ofs[r*OFS_W +: OFS_W]));
    end
  end

  always_ff @(posedge clk) begin
    s2Acc     <= acc;
    s2Clip    <= s1Clip;
    s2Clamp   <= s1Clamp;
    s2ClipEn  <= s1ClipEn;
    s2ClampEn <= s1ClampEn;
  end

  // Stage 3: upper bound, lower bound, then saturation to the pixel range.
  logic signed [ACC_W-1:0] lim [NUM_CH];
  logic [NUM_CH*PIX_W-1:0] limPix;

  always_comb begin
    for (int r = 0; r < NUM_CH; r++) begin
      lim[r] = s2Acc[r];
      if (s2ClipEn && lim[r] > $signed({{(ACC_W-PIX_W){1'b0}}, s2Clip}))
        lim[r] = $signed({{(ACC_W-PIX_W){1'b0}}, s2Clip});
      if (s2ClampEn && lim[r] < $signed({{(ACC_W-PIX_W){1'b0}}, s2Clamp}))
        lim[r] = $signed({{(ACC_W-PIX_W){1'b0}}, s2Clamp});
      if (lim[r] < 0)
        limPix[(NUM_CH-1-r)*PIX_W +: PIX_W] = '0;
      else if (lim[r] > ACC_W'(MAXV))
        limPix[(NUM_CH-1-r)*PIX_W +: PIX_W] = PIX_W'(MAXV);
      else
        limPix[(NUM_CH-1-r)*PIX_W +: PIX_W] = lim[r][PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) outPix <= limPix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      s2Valid  <= s1Valid;
      outValid <= s2Valid;
    end
  end

  // R8
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> ##2 outValid);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ##2 !outValid);

  for (genvar r = 0; r < NUM_CH; r++) begin : g_lim_chk
    // R4
    clip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2Valid && s2ClipEn && !s2ClampEn)
        |=> outPix[r*PIX_W +: PIX_W] <= $past(s2Clip));
    // R5
    clamp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2Valid && s2ClampEn)
        |=> outPix[r*PIX_W +: PIX_W] >= $past(s2Clamp));
  end
endmodule

// File: rtl/color_matrix_top.sv
module color_matrix_top
  import color_matrix_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 12,
  parameter int OFS_W  = PIX_W + 1,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfgWe,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [DATA_W-1:0]       cfgData,
  input  logic                    inValid,
  input  logic                    inSof,
  input  logic [NUM_CH*PIX_W-1:0] inPix,
  output logic                    outValid,
  output logic [NUM_CH*PIX_W-1:0] outPix
);
  ccm_strobe_t                strb;
  logic [NUM_COEF*COEF_W-1:0] coefFlat;
  logic [NUM_CH*OFS_W-1:0]    ofsFlat;
  logic [PIX_W-1:0]           clipMax, clampMin;

  color_matrix_ctrl #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .OFS_W(OFS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inSof(inSof), .strb(strb), .coefFlat(coefFlat),
    .ofsFlat(ofsFlat), .clipMax(clipMax), .clampMin(clampMin)
  );

  color_matrix_dp #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .coefFlat(coefFlat), .ofsFlat(ofsFlat),
    .clipMax(clipMax), .clampMin(clampMin), .inValid(inValid), .inPix(inPix),
    .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: tb/color_matrix_top_tb_top.sv
module color_matrix_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic        inSof = 1'b0;
  logic [23:0] inPix = '0;
  logic        outValid;
  logic [23:0] outPix;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curReq  = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  color_matrix_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .outValid(outValid), .outPix(outPix)
  );

  // Reference settings: shadow and active copies.
  int sk[9], ak[9], so[3], ao[3];
  int sClip, aClip, sClamp, aClamp, sMode, aMode;

  function automatic void resetModel();
    for (int i = 0; i < 9; i++) begin
      sk[i] = (i % 4 == 0) ? 4096 : 0;
      ak[i] = sk[i];
    end
    for (int i = 0; i < 3; i++) begin so[i] = 0; ao[i] = 0; end
    sClip = 255; aClip = 255; sClamp = 0; aClamp = 0; sMode = 6; aMode = 6;
  endfunction

  function automatic logic [23:0] model(logic [23:0] p);
    longint x[3];
    longint s;
    logic [23:0] res;
    for (int c = 0; c < 3; c++) begin
      x[c] = longint'(p[(2-c)*8 +: 8]);
      if (aMode[0]) x[c] = 255 - x[c];
    end
    for (int r = 0; r < 3; r++) begin
      s = 0;
      for (int c = 0; c < 3; c++) s += longint'(ak[r*3+c]) * x[c];
      s = (s + 2048) >>> 12;
      s += ao[r];
      if (aMode[1] && s > aClip)  s = aClip;
      if (aMode[2] && s < aClamp) s = aClamp;
      if (s < 0)   s = 0;
      if (s > 255) s = 255;
      res[(2-r)*8 +: 8] = s[7:0];
    end
    return res;
  endfunction

  logic        eV[3];
  logic [23:0] eP[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      resetModel();
      for (int i = 0; i < 3; i++) begin eV[i] <= 1'b0; eP[i] <= '0; end
    end else begin
      if (inValid && inSof) begin
        ak = sk; ao = so; aClip = sClip; aClamp = sClamp; aMode = sMode;
      end
      eV[0] <= inValid;
      eP[0] <= inValid ? model(inPix) : '0;
      eV[1] <= eV[0]; eP[1] <= eP[0];
      eV[2] <= eV[1]; eP[2] <= eP[1];
      if (cfgWe) begin
        if (cfgAddr < 9)                    sk[cfgAddr] = int'($signed(cfgData));
        else if (cfgAddr < 12)              so[cfgAddr-9] = int'($signed(cfgData[8:0]));
        else if (cfgAddr == 12)             sClip = int'(cfgData[7:0]);
        else if (cfgAddr == 13)             sClamp = int'(cfgData[7:0]);
        else if (cfgAddr == 14)             sMode = int'(cfgData[2:0]);
      end
    end
  end

  // Output comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done && (eV[2] || outValid)) begin
      nChecks++;
      if (outValid !== eV[2] || (eV[2] && outPix !== eP[2])) begin
        nFails++;
        $display("FAIL %s: outValid=%0b outPix=%06h expected outValid=%0b outPix=%06h",
                 curReq, outValid, outPix, eV[2], eP[2]);
      end
    end
  end

  task automatic step(bit we, int addr, int data, bit v, bit sof, logic [23:0] pix);
    @(negedge clk);
    cfgWe = we; cfgAddr = 4'(addr); cfgData = 16'(data);
    inValid = v; inSof = sof; inPix = pix;
  endtask

  task automatic wr(int addr, int data);
    step(1'b1, addr, data, 1'b0, 1'b0, '0);
  endtask

  task automatic px(logic [23:0] pix, bit sof);
    step(1'b0, 0, 0, 1'b1, sof, pix);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, '0);
  endtask

  task automatic identity();
    for (int i = 0; i < 9; i++) wr(i, (i % 4 == 0) ? 4096 : 0);
    for (int i = 9; i < 12; i++) wr(i, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    nChecks++;
    if (outValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1: outValid=%0b expected 0 in reset", outValid);
    end
    rst_n = 1'b1;
    idle(2);
    curReq = "R1";
    px(24'h123456, 1'b1);
    for (int i = 0; i < 15; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R7: complemented input with identity weights
    curReq = "R7";
    wr(14, 7);
    px(24'h00FF80, 1'b1);
    for (int i = 0; i < 10; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R4: upper bound
    curReq = "R4";
    wr(14, 2); wr(12, 200);
    px(24'hFFC8C9, 1'b1);
    for (int i = 0; i < 10; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R5: lower bound after upper bound, with negative offsets
    curReq = "R5";
    wr(14, 6); wr(13, 30); wr(12, 255);
    wr(9, -100 & 16'h1FF); wr(10, -100 & 16'h1FF); wr(11, 0);
    px(24'h641E1D, 1'b1);
    wr(12, 20);
    px(24'hFF0010, 1'b1);
    for (int i = 0; i < 8; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R6: saturation with both bounds disabled
    curReq = "R6";
    wr(14, 0); wr(13, 0); wr(12, 255);
    wr(9, 200); wr(10, -200 & 16'h1FF); wr(11, 0);
    wr(8, -4096 & 16'hFFFF);
    px(24'h80FF01, 1'b1);
    for (int i = 0; i < 8; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R3: distinct per-channel offsets
    curReq = "R3";
    identity(); wr(14, 6);
    wr(9, 5); wr(10, -7 & 16'h1FF); wr(11, 100);
    px(24'h101010, 1'b1);
    for (int i = 0; i < 8; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R2: exact halves round toward +infinity
    curReq = "R2";
    identity();
    wr(0, 16'h0800); wr(4, 16'hF800); wr(10, 10);
    px(24'h030303, 1'b1);
    px(24'h010101, 1'b0);
    px(24'h050705, 1'b0);
    idle(4);

    // R10: off-diagonal weight moves red input to green output
    curReq = "R10";
    identity();
    wr(3, 4096); wr(4, 0); wr(2, 2048);
    px(24'hA05020, 1'b1);
    for (int i = 0; i < 6; i++) px(24'($urandom), 1'b0);
    idle(4);

    // R9: writes stay hidden until start of frame; old pixels still in flight
    curReq = "R9";
    identity();
    px(24'h406080, 1'b1);
    wr(9, 50); wr(0, 16'h2000); wr(14, 0);
    px(24'h406080, 1'b0);
    px(24'h102030, 1'b0);
    px(24'h406080, 1'b1);
    px(24'h102030, 1'b0);
    idle(4);

    // R8: streaming with random gaps and random settings
    curReq = "R8";
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 9; i++) wr(i, int'($urandom_range(0, 16383)) - 8192);
      for (int i = 9; i < 12; i++) wr(i, (int'($urandom_range(0, 160)) - 80) & 16'h1FF);
      wr(12, int'($urandom_range(150, 255)));
      wr(13, int'($urandom_range(0, 100)));
      wr(14, int'($urandom_range(0, 7)));
      px(24'($urandom), 1'b1);
      for (int i = 0; i < 60; i++) begin
        if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        px(24'($urandom), 1'b0);
      end
    end
    idle(5);
    finishRun();
  end
endmodule